// File: doc/BRIEF.md
# UART Sleep Wakeup Detector

This block watches a UART receive path while the system is asleep and decides when that activity is enough to wake it. It has three wakeup criteria, and a two-bit mode input picks one of them. In edge mode it counts level changes on the raw receive pin. In byte mode it counts bytes that the receiver has delivered. In character mode it waits for a programmed sequence of up to five wakeup characters. When the chosen criterion is met, the block issues a single-cycle wakeup request and sets a sticky raw interrupt flag.

The receive pin passes through a two-flop synchronizer before its edges are counted. Received bytes arrive from an external receiver as a strobe together with the data. All detection is gated by a sleep flag. The counters and the match position are cleared whenever the sleep flag is low, and also in the cycle after a wakeup is issued, so each stay in sleep starts from zero.

Top module: `uart_wake_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wake_req` and `wake_raw` are 0.
- R2: Mode 0 (edge counting) with threshold T: the (T+1)th change of `rxd` seen during sleep raises `wake_req` for one cycle. This happens three clock edges after the `rxd` change, two for the synchronizer and one for the output register.
- R3: Mode 1 (byte counting) with threshold T: the (T+1)th `rx_byte_vld` strobe seen during sleep raises `wake_req` in the cycle after that strobe.
- R4: Mode 2 (character match). Slot i is enabled when i < `char_count` and `char_mask[i]` is 0, and its character sits in `wake_chars[8*i+7:8*i]`. Wakeup is raised in the cycle after the byte that completes the enabled slots, received in ascending slot order.
- R5: In mode 2, a byte that does not equal the expected character restarts the match. If that byte equals the first enabled character, it counts as the first match of the new attempt.
- R6: A masked slot is skipped entirely: its character is neither expected nor required.
- R7: While `in_sleep` is 0, no edge, byte or character is counted and no wakeup is raised. Any partial count is discarded, so after re-entering sleep the full threshold applies again.
- R8: After a wakeup, the counters and the match position restart from zero, so a second wakeup needs the full criterion again.
- R9: `wake_raw` goes to 1 with every `wake_req` and stays at 1 until a cycle with `wake_clr` high. A new wakeup in the same cycle as `wake_clr` leaves it at 1.
- R10: Mode 3 never wakes. Mode 2 with no enabled slot never wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sleep | input | 1 | High while the system is in light sleep |
| rxd | input | 1 | Raw, asynchronous receive pin level |
| rx_byte_vld | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte data, valid with the strobe |
| mode_sel | input | 2 | 0 edges, 1 bytes, 2 character match, 3 off |
| edge_thresh | input | 10 | Edge-count threshold |
| byte_thresh | input | 5 | Byte-count threshold |
| wake_chars | input | 40 | Five wakeup characters, slot i at bits 8i+7:8i |
| char_count | input | 3 | Number of slots in use (values above 5 act as 5) |
| char_mask | input | 5 | Bit i set excludes slot i |
| wake_clr | input | 1 | Clears the sticky raw flag |
| wake_req | output | 1 | Single-cycle wakeup request |
| wake_raw | output | 1 | Sticky raw wakeup interrupt |

## Verification
Edge and byte modes are driven with exactly T events followed by one more, at thresholds 0, small random values, the default and the field maximum. This separates a "greater than" trigger from "greater or equal" or off-by-one variants, and repeated rounds show that the count restarts after a wakeup. Character mode is tried with directed sequences that contain interrupted matches, a repeated first character, masked slots and shortened counts. It is then given long random byte streams drawn mostly from the wakeup alphabet, under random counts and masks, which expose wrong restart and skip rules. Sleep toggling in the middle of a count, together with mode 3 and mode 2 without enabled slots, shows that stray activity is discarded.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {
    WK_EDGES = 2'd0,
    WK_BYTES = 2'd1,
    WK_CHARS = 2'd2,
    WK_OFF   = 2'd3
  } wake_mode_e;
endpackage

// File: rtl/rxd_edge_sync.sv
module rxd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic edge_o
);
  // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds previous level
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[SYNC_STAGES-1:0], rxd};
  end

  assign edge_o = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/wake_event_counter.sv
module wake_event_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;

  // the event that takes the count past the threshold fires
  assign hit = inc && (cnt >= thresh);

  always_ff @(posedge clk) begin
    if (rst || clr)               cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wake_char_match.sv
module wake_char_match #(
  parameter int NCHAR  = 5,
  parameter int CHAR_W = 8,
  parameter int NUM_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    byte_vld,
  input  logic [CHAR_W-1:0]       byte_in,
  input  logic [NCHAR*CHAR_W-1:0] chars,
  input  logic [NUM_W-1:0]        use_num,
  input  logic [NCHAR-1:0]        mask,
  output logic                    hit
);
  localparam int PW = $clog2(NCHAR + 1);

  logic [CHAR_W-1:0] ch [NCHAR];
  logic [NCHAR-1:0]  en;
  logic [PW-1:0]     ptr, ptr_d, cur_idx, first_idx;
  logic              cur_ok, nxt_ok, any_en;
  logic [CHAR_W-1:0] cur_char, first_char;

  for (genvar g = 0; g < NCHAR; g++) begin : g_slot
    assign ch[g] = chars[g*CHAR_W +: CHAR_W];
    assign en[g] = (g < int'(use_num)) && !mask[g];
  end

  assign any_en = |en;

  // locate first enabled slot, expected slot at or after ptr, and its successor
  always_comb begin
    first_idx  = '0;
    first_char = '0;
    cur_idx    = '0;
    cur_char   = '0;
    cur_ok     = 1'b0;
    nxt_ok     = 1'b0;
    for (int i = NCHAR - 1; i >= 0; i--) begin
      if (en[i]) begin
        first_idx  = PW'(i);
        first_char = ch[i];
      end
      if (en[i] && i >= int'(ptr)) begin
        cur_ok   = 1'b1;
        cur_idx  = PW'(i);
        cur_char = ch[i];
      end
    end
    for (int i = 0; i < NCHAR; i++) begin
      if (en[i] && cur_ok && i > int'(cur_idx)) nxt_ok = 1'b1;
    end
  end

  assign hit = byte_vld && cur_ok && (byte_in == cur_char) && !nxt_ok;

  always_comb begin
    ptr_d = ptr;
    if (byte_vld) begin
      if (cur_ok && byte_in == cur_char)
        ptr_d = nxt_ok ? cur_idx + PW'(1) : '0;
      else if (any_en && byte_in == first_char)
        ptr_d = first_idx + PW'(1);
      else
        ptr_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else            ptr <= ptr_d;
  end
endmodule

// File: rtl/uart_wake_detect.sv
module uart_wake_detect
  import uart_wake_pkg::*;
#(
  parameter int EDGE_W      = 10,
  parameter int BYTE_W      = 5,
  parameter int NCHAR       = 5,
  parameter int CHAR_W      = 8,
  parameter int NUM_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_sleep,
  input  logic                    rxd,
  input  logic                    rx_byte_vld,
  input  logic [CHAR_W-1:0]       rx_byte,
  input  logic [1:0]              mode_sel,
  input  logic [EDGE_W-1:0]       edge_thresh,
  input  logic [BYTE_W-1:0]       byte_thresh,
  input  logic [NCHAR*CHAR_W-1:0] wake_chars,
  input  logic [NUM_W-1:0]        char_count,
  input  logic [NCHAR-1:0]        char_mask,
  input  logic                    wake_clr,
  output logic                    wake_req,
  output logic                    wake_raw
);
  wake_mode_e mode;
  logic rx_edge, hit_edges, hit_bytes, hit_chars, hit_any, clr_all;
  logic inc_edges, inc_bytes, vld_chars;

  assign mode = wake_mode_e'(mode_sel);

  rxd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd(rxd), .edge_o(rx_edge)
  );

  assign inc_edges = in_sleep && (mode == WK_EDGES) && rx_edge;
  assign inc_bytes = in_sleep && (mode == WK_BYTES) && rx_byte_vld;
  assign vld_chars = in_sleep && (mode == WK_CHARS) && rx_byte_vld;

  always_comb begin
    unique case (mode)
      WK_EDGES: hit_any = hit_edges;
      WK_BYTES: hit_any = hit_bytes;
      WK_CHARS: hit_any = hit_chars;
      default:  hit_any = 1'b0;
    endcase
  end

  // leaving sleep or issuing a wakeup restarts every criterion
  assign clr_all = !in_sleep || hit_any;

  wake_event_counter #(.CNT_W(EDGE_W)) u_edges (
    .clk(clk), .rst(rst), .clr(clr_all), .inc(inc_edges),
    .thresh(edge_thresh), .hit(hit_edges)
  );

  wake_event_counter #(.CNT_W(BYTE_W)) u_bytes (
    .clk(clk), .rst(rst), .clr(clr_all), .inc(inc_bytes),
    .thresh(byte_thresh), .hit(hit_bytes)
  );

  wake_char_match #(.NCHAR(NCHAR), .CHAR_W(CHAR_W), .NUM_W(NUM_W)) u_match (
    .clk(clk), .rst(rst), .clr(clr_all), .byte_vld(vld_chars),
    .byte_in(rx_byte), .chars(wake_chars), .use_num(char_count),
    .mask(char_mask), .hit(hit_chars)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_req <= 1'b0;
      wake_raw <= 1'b0;
    end else begin
      wake_req <= hit_any;
      wake_raw <= hit_any || (wake_raw && !wake_clr);
    end
  end
endmodule

// File: rtl/uart_wake_detect_chk.sv
module uart_wake_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_sleep,
  input logic       rx_byte_vld,
  input logic [1:0] mode_sel,
  input logic       wake_clr,
  input logic       wake_req,
  input logic       wake_raw
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wake_req && !wake_raw));

  a_r7_sleep_only: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(in_sleep));

  a_r9_raw_with_req: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> wake_raw);

  a_r9_raw_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_raw) |-> wake_req);

  a_r9_raw_hold: assert property (@(posedge clk) disable iff (rst)
    (wake_raw && !wake_clr) |=> wake_raw);

  a_r10_mode_off: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ($past(mode_sel) != 2'd3));

  // byte and character modes (R3, R4) only fire on a strobe
  a_r3_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (wake_req && $past(mode_sel) != 2'd0) |-> $past(rx_byte_vld));
endmodule

bind uart_wake_detect uart_wake_detect_chk u_chk (
  .clk(clk), .rst(rst), .in_sleep(in_sleep), .rx_byte_vld(rx_byte_vld),
  .mode_sel(mode_sel), .wake_clr(wake_clr), .wake_req(wake_req),
  .wake_raw(wake_raw)
);

// File: tb/uart_wake_detect_bench.sv
module uart_wake_detect_bench;
  logic        clk = 1'b0;
  logic        rst, in_sleep, rxd, rx_byte_vld, wake_clr;
  logic [7:0]  rx_byte;
  logic [1:0]  mode_sel;
  logic [9:0]  edge_thresh;
  logic [4:0]  byte_thresh;
  logic [39:0] wake_chars;
  logic [2:0]  char_count;
  logic [4:0]  char_mask;
  logic        wake_req, wake_raw;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_wake_detect u_uart_wake_detect (
    .clk(clk), .rst(rst), .in_sleep(in_sleep), .rxd(rxd),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .mode_sel(mode_sel),
    .edge_thresh(edge_thresh), .byte_thresh(byte_thresh),
    .wake_chars(wake_chars), .char_count(char_count), .char_mask(char_mask),
    .wake_clr(wake_clr), .wake_req(wake_req), .wake_raw(wake_raw)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  // change rxd and observe wake_req three edges later
  task automatic toggle(output logic w);
    rxd = ~rxd;
    repeat (3) @(negedge clk);
    w = wake_req;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic w);
    rx_byte = b; rx_byte_vld = 1'b1;
    @(negedge clk);
    rx_byte_vld = 1'b0;
    w = wake_req;
  endtask

  task automatic resleep();
    in_sleep = 1'b0; @(negedge clk);
    in_sleep = 1'b1; @(negedge clk);
  endtask

  task automatic clear_raw();
    wake_clr = 1'b1; @(negedge clk); wake_clr = 1'b0;
  endtask

  task automatic edge_rounds(input int t, input int rounds, input string req);
    logic w;
    mode_sel = 2'd0; edge_thresh = 10'(t); resleep();
    for (int r = 0; r < rounds; r++)
      for (int k = 1; k <= t + 1; k++) begin
        toggle(w);
        check(req, w, (k == t + 1));
      end
  endtask

  task automatic byte_rounds(input int t, input int rounds, input string req);
    logic w;
    mode_sel = 2'd1; byte_thresh = 5'(t); resleep();
    for (int r = 0; r < rounds; r++)
      for (int k = 1; k <= t + 1; k++) begin
        put_byte(8'($urandom), w);
        check(req, w, (k == t + 1));
      end
  endtask

  // reference for character mode: compacted sequence and position
  logic [7:0] seq [5];
  int mlen, mpos;

  function automatic void model_setup();
    mlen = 0; mpos = 0;
    for (int i = 0; i < 5; i++)
      if (i < int'(char_count) && !char_mask[i]) begin
        seq[mlen] = wake_chars[8*i +: 8]; mlen++;
      end
  endfunction

  function automatic int model_byte(input logic [7:0] b);
    if (mlen == 0) return 0;
    if (b == seq[mpos]) mpos++;
    else mpos = (b == seq[0]) ? 1 : 0;
    if (mpos == mlen) begin mpos = 0; return 1; end
    return 0;
  endfunction

  task automatic char_seq(input string req, input string s);
    logic w;
    for (int i = 0; i < s.len(); i++) begin
      put_byte(s[i], w);
      check(req, w, model_byte(s[i]));
    end
  endtask

  task automatic char_cfg(input int cnt, input logic [4:0] msk);
    mode_sel = 2'd2; char_count = 3'(cnt); char_mask = msk;
    resleep(); model_setup();
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: got timeout expected completion");
    nbad++; nvec++;
    finish_run();
  end

  initial begin
    logic w;
    void'($urandom(32'h5eed));
    rst = 1; in_sleep = 0; rxd = 1; rx_byte_vld = 0; rx_byte = 0; wake_clr = 0;
    mode_sel = 0; edge_thresh = 10'd240; byte_thresh = 5'd1;
    wake_chars = {8'h45, 8'h44, 8'h43, 8'h42, 8'h41};
    char_count = 3'd5; char_mask = 5'd0;
    repeat (3) @(negedge clk);
    check("R1 req", wake_req, 0); check("R1 raw", wake_raw, 0);
    rst = 0; @(negedge clk);
    check("R1 req", wake_req, 0); check("R1 raw", wake_raw, 0);

    // R2 / R8: edge thresholds incl. zero, default and random
    edge_rounds(0, 3, "R2 t0");
    edge_rounds(3, 2, "R8 edges");
    edge_rounds(240, 1, "R2 t240");
    for (int n = 0; n < 4; n++) edge_rounds(1 + $urandom_range(0, 19), 2, "R2 rand");

    // R7: no counting awake, partial count discarded
    mode_sel = 0; edge_thresh = 10'd3; in_sleep = 0; @(negedge clk);
    for (int k = 0; k < 8; k++) begin toggle(w); check("R7 awake", w, 0); end
    in_sleep = 1; @(negedge clk);
    for (int k = 0; k < 3; k++) begin toggle(w); check("R7 partial", w, 0); end
    resleep();
    for (int k = 1; k <= 4; k++) begin toggle(w); check("R7 restart", w, (k == 4)); end

    // R3 / R8: byte thresholds incl. 0, default 1 and maximum 31
    byte_rounds(0, 3, "R3 t0");
    byte_rounds(1, 2, "R8 bytes");
    byte_rounds(31, 1, "R3 t31");
    for (int n = 0; n < 4; n++) byte_rounds($urandom_range(0, 15), 2, "R3 rand");
    in_sleep = 0; byte_thresh = 0;
    for (int k = 0; k < 4; k++) begin put_byte(8'h55, w); check("R7 bytes awake", w, 0); end

    // R9: sticky raw flag
    check("R9 sticky", wake_raw, 1);
    repeat (5) @(negedge clk);
    check("R9 held", wake_raw, 1);
    clear_raw();
    check("R9 cleared", wake_raw, 0);
    byte_rounds(0, 0, "R9");
    wake_clr = 1; put_byte(8'h00, w); wake_clr = 0;
    check("R9 set wins req", w, 1); check("R9 set wins", wake_raw, 1);
    clear_raw();

    // R10: mode 3 is inert
    mode_sel = 2'd3; resleep();
    for (int k = 0; k < 6; k++) begin toggle(w); check("R10 off edges", w, 0); end
    for (int k = 0; k < 6; k++) begin put_byte(8'h41, w); check("R10 off bytes", w, 0); end

    // R4 / R5 / R6 directed character cases
    char_cfg(5, 5'b00000); char_seq("R4 full", "ABCDE");
    char_seq("R5 restart", "ABXABCDE");
    char_seq("R5 first reuse", "AABCDE");
    char_cfg(5, 5'b00100); char_seq("R6 skip", "ABDE");
    char_seq("R6 masked absent", "ABCDE");
    char_cfg(3, 5'b00000); char_seq("R4 count3", "ABCABC");
    char_cfg(5, 5'b00001); char_seq("R6 first masked", "ABCDEBCDE");
    char_cfg(0, 5'b00000); char_seq("R10 none", "ABCDE");
    char_cfg(5, 5'b11111); char_seq("R10 allmask", "ABCDE");
    char_cfg(7, 5'b00000); char_seq("R4 count7", "ABCDE");

    // random streams against the reference
    for (int n = 0; n < 12; n++) begin
      char_cfg($urandom_range(1, 5), 5'($urandom) & 5'b10110);
      for (int k = 0; k < 150; k++) begin
        logic [7:0] b;
        b = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h41 + 8'($urandom_range(0, 4));
        put_byte(b, w);
        check("R4 random", w, model_byte(b));
      end
    end

    finish_run();
  end
endmodule